// File: doc/BRIEF.md
# Delay-Slot Next-PC Sequencer

This block holds the three program-counter registers of a fetch front end for a 32-bit instruction set that has a single branch delay slot. The registers are the address being executed (PC), the delay-slot or sequential successor (NPC), and the address after that (NNPC). On each advance step the block reads one decoded control-transfer descriptor for the instruction at PC. It then produces the new address triple and, when the link flag is set, a write request for the return-address register.

The descriptor carries the transfer kind, a link flag, an already-resolved condition, a 16-bit branch offset, a 26-bit jump index and a register operand. Branches redirect the address that follows the delay slot, so the slot instruction always runs. The exception is a branch-likely that is not taken, which skips the slot. A transfer that sits in the delay slot of another transfer is rejected: the block reports an error and treats it as a plain instruction.

Top module: `npc_seq`

## Requirements
- R1: A synchronous active-high reset loads PC with the parameter RESET_VEC, NPC with RESET_VEC+4 and NNPC with RESET_VEC+8.
- R2: While step is low, PC, NPC and NNPC hold their values and link_we is low.
- R3: A step with kind 0 (no transfer) moves NPC into PC and NNPC into NPC, and sets NNPC to the old NNPC+4. After any step, NNPC equals NPC+4.
- R4: The branch displacement is the offset placed at bits 17:2 with bits 1:0 zero, sign-extended from bit 17 to 32 bits. For example, offset 16'h8000 gives 32'hFFFE0000.
- R5: A taken branch (kind 1, or kind 2 with cond high) moves old NPC into PC, sets NPC to old NPC plus the displacement, and sets NNPC to that target plus 4.
- R6: A branch of kind 1 with cond low behaves exactly like kind 0.
- R7: A branch of kind 2 with cond low skips the delay slot: PC becomes old NNPC, NPC becomes old NNPC+4 and NNPC becomes old NNPC+8.
- R8: When a transfer of kind 1 to 4 is accepted with link set, link_we is high during that step whether or not the branch is taken, and link_data equals the current NNPC.
- R9: Kind 3 (absolute jump) moves old NPC into PC and sets NPC to the target {old NPC[31:28], index, 2'b00}.
- R10: Kind 4 (register jump) moves old NPC into PC and sets NPC to the register operand with bits 1:0 cleared.
- R11: A transfer of kind 1 to 4 that arrives while PC is the delay slot of an accepted transfer raises slot_err during that step. It writes no link and advances like kind 0. A squashed branch-likely opens no slot.
- R12: Kinds 5 to 7 behave exactly like kind 0 and never raise slot_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Advance the sequence by one instruction |
| xfer_kind | input | 3 | 0 none, 1 branch, 2 branch-likely, 3 absolute jump, 4 register jump |
| xfer_link | input | 1 | Write the return address |
| xfer_cond | input | 1 | Resolved branch condition |
| br_off | input | 16 | Branch word offset |
| jmp_idx | input | 26 | Absolute jump word index |
| reg_opnd | input | 32 | Register jump operand |
| pc_o | output | 32 | Current instruction address |
| npc_o | output | 32 | Next address (delay slot) |
| nnpc_o | output | 32 | Address after next |
| link_we | output | 1 | Return-address write strobe |
| link_data | output | 32 | Return-address value |
| slot_err | output | 1 | Transfer found in a delay slot |

## Verification
A wrong delay-slot flag shows up in the same step, either as a spurious slot_err or a missing one, and one edge later as a redirect that should not have happened or one that was lost. A corrupted triple entry reaches pc_o within two steps, because every step shifts the registers by one place, and the NNPC = NPC+4 relation exposes a stale NNPC at once. Sweeping kind, condition, link and offset sign with back-to-back transfers covers both the accepted-transfer and the rejected-in-slot paths.

// File: rtl/npc_seq_pkg.sv
package npc_seq_pkg;
    localparam int AW = 32;
    localparam int OFF_W = 16;
    localparam int IDX_W = 26;
    localparam int REGION_W = AW - IDX_W - 2;

    typedef enum logic [2:0] {
        XK_NONE = 3'd0,
        XK_BR   = 3'd1,
        XK_BRL  = 3'd2,
        XK_JABS = 3'd3,
        XK_JREG = 3'd4
    } xkind_e;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] npc;
        logic [AW-1:0] nnpc;
    } pc_trip_t;

    function automatic logic [AW-1:0] br_disp(input logic [OFF_W-1:0] off);
        return {{(AW-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    endfunction

    function automatic logic [AW-1:0] jabs_target(input logic [AW-1:0] slot_addr,
                                                  input logic [IDX_W-1:0] idx);
        return {slot_addr[AW-1 -: REGION_W], idx, 2'b00};
    endfunction

    function automatic logic is_xfer(input logic [2:0] k);
        return (k >= 3'd1) && (k <= 3'd4);
    endfunction
endpackage

// File: rtl/npc_redirect.sv
module npc_redirect
    import npc_seq_pkg::*;
(
    input  pc_trip_t          cur,
    input  logic [2:0]        kind,
    input  logic              cond,
    input  logic              suppress,
    input  logic [OFF_W-1:0]  off,
    input  logic [IDX_W-1:0]  idx,
    input  logic [AW-1:0]     regop,
    output pc_trip_t          nxt,
    output logic              opens_slot
);
    logic [AW-1:0] br_tgt;
    logic [AW-1:0] tgt;
    logic          redirect;

    assign br_tgt = cur.npc + br_disp(off);

    always_comb begin
        redirect   = 1'b0;
        opens_slot = 1'b0;
        tgt        = br_tgt;
        nxt.pc     = cur.npc;
        nxt.npc    = cur.nnpc;
        nxt.nnpc   = cur.nnpc + 32'd4;
        if (!suppress) begin
            case (kind)
                XK_BR: begin
                    opens_slot = 1'b1;
                    redirect   = cond;
                end
                XK_BRL: begin
                    opens_slot = cond;
                    redirect   = cond;
                    if (!cond) begin
                        nxt.pc   = cur.nnpc;
                        nxt.npc  = cur.nnpc + 32'd4;
                        nxt.nnpc = cur.nnpc + 32'd8;
                    end
                end
                XK_JABS: begin
                    opens_slot = 1'b1;
                    redirect   = 1'b1;
                    tgt        = jabs_target(cur.npc, idx);
                end
                XK_JREG: begin
                    opens_slot = 1'b1;
                    redirect   = 1'b1;
                    tgt        = {regop[AW-1:2], 2'b00};
                end
                default: ;
            endcase
        end
        if (redirect) begin
            nxt.npc  = tgt;
            nxt.nnpc = tgt + 32'd4;
        end
    end
endmodule

// File: rtl/npc_slot_track.sv
module npc_slot_track (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic opens_slot,
    output logic in_slot
);
    always_ff @(posedge clk) begin
        if (rst)       in_slot <= 1'b0;
        else if (step) in_slot <= opens_slot;
    end
endmodule

// File: rtl/npc_seq.sv
module npc_seq
    import npc_seq_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic [2:0]  xfer_kind,
    input  logic        xfer_link,
    input  logic        xfer_cond,
    input  logic [15:0] br_off,
    input  logic [25:0] jmp_idx,
    input  logic [31:0] reg_opnd,
    output logic [31:0] pc_o,
    output logic [31:0] npc_o,
    output logic [31:0] nnpc_o,
    output logic        link_we,
    output logic [31:0] link_data,
    output logic        slot_err
);
    pc_trip_t trip_q;
    pc_trip_t trip_d;
    logic     in_slot;
    logic     opens_slot;
    logic     xfer_here;

    assign xfer_here = is_xfer(xfer_kind);
    assign slot_err  = step && in_slot && xfer_here;

    npc_redirect u_redirect (
        .cur        (trip_q),
        .kind       (xfer_kind),
        .cond       (xfer_cond),
        .suppress   (in_slot),
        .off        (br_off),
        .idx        (jmp_idx),
        .regop      (reg_opnd),
        .nxt        (trip_d),
        .opens_slot (opens_slot)
    );

    npc_slot_track u_slot (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .opens_slot (opens_slot),
        .in_slot    (in_slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_q.pc   <= RESET_VEC;
            trip_q.npc  <= RESET_VEC + 32'd4;
            trip_q.nnpc <= RESET_VEC + 32'd8;
        end else if (step) begin
            trip_q <= trip_d;
        end
    end

    assign link_we   = step && xfer_here && xfer_link && !in_slot;
    assign link_data = trip_q.nnpc;
    assign pc_o      = trip_q.pc;
    assign npc_o     = trip_q.npc;
    assign nnpc_o    = trip_q.nnpc;
endmodule

// File: rtl/npc_seq_chk.sv
module npc_seq_chk #(
    parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        step,
    input logic [2:0]  xfer_kind,
    input logic [31:0] pc_o,
    input logic [31:0] npc_o,
    input logic [31:0] nnpc_o,
    input logic        link_we,
    input logic [31:0] link_data,
    input logic        slot_err
);
    a_r1_reset_vec: assert property (@(posedge clk)
        $past(rst) && !rst |-> pc_o == RESET_VEC && npc_o == RESET_VEC + 32'd4);

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc_o) && $stable(npc_o) && $stable(nnpc_o));

    a_r2_no_link_idle: assert property (@(posedge clk) disable iff (rst)
        !step |-> !link_we);

    a_r3_pair: assert property (@(posedge clk) disable iff (rst)
        nnpc_o == npc_o + 32'd4);

    a_r3_shift: assert property (@(posedge clk) disable iff (rst)
        step && xfer_kind == 3'd0 |=> pc_o == $past(npc_o) && npc_o == $past(nnpc_o));

    a_r8_link_val: assert property (@(posedge clk) disable iff (rst)
        link_we |-> link_data == nnpc_o);

    a_r11_no_link: assert property (@(posedge clk) disable iff (rst)
        slot_err |-> !link_we);

    a_r11_ignored: assert property (@(posedge clk) disable iff (rst)
        slot_err |=> pc_o == $past(npc_o) && npc_o == $past(nnpc_o));

    a_r12_no_err: assert property (@(posedge clk) disable iff (rst)
        xfer_kind > 3'd4 |-> !slot_err);
endmodule

bind npc_seq npc_seq_chk #(.RESET_VEC(RESET_VEC)) u_chk (
    .clk(clk), .rst(rst), .step(step), .xfer_kind(xfer_kind),
    .pc_o(pc_o), .npc_o(npc_o), .nnpc_o(nnpc_o),
    .link_we(link_we), .link_data(link_data), .slot_err(slot_err)
);

// File: tb/npc_seq_tb.sv
module npc_seq_tb;
    localparam logic [31:0] VEC = 32'hBFC0_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        step;
    logic [2:0]  xfer_kind;
    logic        xfer_link;
    logic        xfer_cond;
    logic [15:0] br_off;
    logic [25:0] jmp_idx;
    logic [31:0] reg_opnd;
    logic [31:0] pc_o, npc_o, nnpc_o, link_data;
    logic        link_we, slot_err;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_pc, m_npc, m_nnpc;
    logic        m_slot;

    always #10 clk = ~clk;

    npc_seq #(.RESET_VEC(VEC)) u_dut (
        .clk(clk), .rst(rst), .step(step), .xfer_kind(xfer_kind),
        .xfer_link(xfer_link), .xfer_cond(xfer_cond), .br_off(br_off),
        .jmp_idx(jmp_idx), .reg_opnd(reg_opnd), .pc_o(pc_o), .npc_o(npc_o),
        .nnpc_o(nnpc_o), .link_we(link_we), .link_data(link_data),
        .slot_err(slot_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] k, input logic c);
        case (k)
            3'd1: return c ? "R5" : "R6";
            3'd2: return c ? "R5" : "R7";
            3'd3: return "R9";
            3'd4: return "R10";
            3'd0: return "R3";
            default: return "R12";
        endcase
    endfunction

    task automatic check_triple(input string req);
        chk(req, pc_o, m_pc);
        chk(req, npc_o, m_npc);
        chk(req, nnpc_o, m_nnpc);
    endtask

    // one step: drive at negedge, check combinational outputs, advance model, check triple
    task automatic do_step(input logic [2:0] k, input logic c, input logic l,
                           input logic [15:0] off, input logic [25:0] idx,
                           input logic [31:0] rop);
        logic        xf, err, redir, opens;
        logic [31:0] disp, tgt;
        string       tag;
        step = 1'b1; xfer_kind = k; xfer_cond = c; xfer_link = l;
        br_off = off; jmp_idx = idx; reg_opnd = rop;
        #1;
        xf  = (k >= 3'd1 && k <= 3'd4);
        err = xf && m_slot;
        tag = err ? "R11" : tag_of(k, c);
        chk("R11 slot_err", {31'd0, slot_err}, {31'd0, err});
        chk("R8 link_we", {31'd0, link_we}, {31'd0, xf && l && !err});
        if (xf && l && !err) chk("R8 link_data", link_data, m_nnpc);
        // model (R4 displacement)
        disp  = {{14{off[15]}}, off, 2'b00};
        tgt   = m_npc + disp;
        redir = 1'b0; opens = 1'b0;
        if (!err) begin
            case (k)
                3'd1: begin opens = 1'b1; redir = c; end
                3'd2: begin opens = c; redir = c; end
                3'd3: begin opens = 1'b1; redir = 1'b1; tgt = {m_npc[31:28], idx, 2'b00}; end
                3'd4: begin opens = 1'b1; redir = 1'b1; tgt = {rop[31:2], 2'b00}; end
                default: ;
            endcase
        end
        @(posedge clk);
        if (!err && k == 3'd2 && !c) begin
            m_pc = m_nnpc; m_npc = m_nnpc + 4; m_nnpc = m_nnpc + 8;
        end else if (redir) begin
            m_pc = m_npc; m_npc = tgt; m_nnpc = tgt + 4;
        end else begin
            m_pc = m_npc; m_npc = m_nnpc; m_nnpc = m_nnpc + 4;
        end
        m_slot = opens;
        @(negedge clk);
        check_triple(tag);
    endtask

    initial begin
        logic [15:0] offs [4];
        offs[0] = 16'h0004; offs[1] = 16'hFFFC; offs[2] = 16'h8000; offs[3] = 16'h7FFF;
        rst = 1'b1; step = 1'b0; xfer_kind = 3'd0; xfer_link = 1'b0; xfer_cond = 1'b0;
        br_off = '0; jmp_idx = '0; reg_opnd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pc = VEC; m_npc = VEC + 4; m_nnpc = VEC + 8; m_slot = 1'b0;
        check_triple("R1");

        // R2: idle cycles hold state and give no link write
        repeat (3) begin
            @(negedge clk);
            check_triple("R2");
            chk("R2 link_we", {31'd0, link_we}, 32'd0);
        end

        // R4 corners: largest negative and positive offsets with a taken branch
        do_step(3'd1, 1'b1, 1'b0, 16'h8000, '0, '0);
        chk("R4 neg disp", npc_o, VEC + 32'd4 + 32'hFFFE_0000);
        do_step(3'd0, 1'b0, 1'b0, '0, '0, '0);
        do_step(3'd0, 1'b0, 1'b0, '0, '0, '0);
        do_step(3'd1, 1'b1, 1'b0, 16'h7FFF, '0, '0);
        chk("R4 pos disp", npc_o, m_pc + 32'h0001_FFFC);
        do_step(3'd0, 1'b0, 1'b0, '0, '0, '0);

        // R9 across a region edge: reg jump to last word of a region (R10 clears low bits)
        do_step(3'd4, 1'b0, 1'b1, '0, '0, 32'h0FFF_FFFF);
        chk("R10 low bits", npc_o, 32'h0FFF_FFFC);
        do_step(3'd0, 1'b0, 1'b0, '0, '0, '0);
        do_step(3'd3, 1'b0, 1'b0, '0, 26'h000_0010, '0);
        chk("R9 region from slot", npc_o, 32'h1000_0040);
        do_step(3'd0, 1'b0, 1'b0, '0, '0, '0);

        // sweep: every kind, cond, link, offset; with and without a leading plain step
        for (int gap = 0; gap < 2; gap++)
            for (int k = 0; k < 8; k++)
                for (int c = 0; c < 2; c++)
                    for (int l = 0; l < 2; l++)
                        for (int o = 0; o < 4; o++) begin
                            if (gap == 1) do_step(3'd0, 1'b0, 1'b0, '0, '0, '0);
                            do_step(3'(k), c[0], l[0], offs[o], 26'h2AA_AAA5 ^ 26'(o), 32'h1234_5677 + 32'(o));
                        end

        // R2 again after activity
        step = 1'b0;
        repeat (2) begin
            @(negedge clk);
            check_triple("R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule